// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit memory read port and a consumer that takes instruction bytes one at a time. It keeps its own fetch offset and reads instruction words ahead of need. The returned bytes go into a small first-in-first-out store, and the consumer drains them with a valid/ready handshake. Fetching carries on while the consumer is busy, so the queue refills in the background and the consumer seldom waits.

A control transfer reloads the fetch offset through a redirect input. In that cycle the queued bytes are dropped, and a word read that is still in flight is marked so that its data is thrown away when it returns. Memory returns a whole aligned word. When the offset is odd, only the upper byte of that word belongs to the stream, so only that byte is kept and the offset steps by one. The block produces a 16-bit offset only. Segment arithmetic and decoding are left to other blocks.

Memory model assumed at the port: a request is taken in the cycle `mem_req_o` is high. The data comes back in some later cycle with `mem_rvalid_i` high. `mem_rdata_i[7:0]` is the byte at the even address `{mem_addr_o[15:1],1'b0}` and `mem_rdata_i[15:8]` is the byte at the next address.

Top module: `insn_prefetch_queue`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the queue is empty (`byte_valid_o` low). No request is made while `rst` is high. The first request after reset carries offset `RESET_ADDR` (default 16'h0040).
- R2: At most one word read is in flight. A request is raised in every cycle where no read is in flight, at least two byte slots are free and no redirect is present. This holds even while bytes are waiting to be consumed.
- R3: A read at an even offset A enqueues byte A first (`mem_rdata_i[7:0]`) and then byte A+1 (`mem_rdata_i[15:8]`). The next request is at A+2.
- R4: A read at an odd offset A enqueues only `mem_rdata_i[15:8]`, which is byte A. The next request is at A+1.
- R5: Bytes leave in arrival order, one per cycle in which `byte_valid_o` and `byte_ready_i` are both high. While the consumer holds `byte_ready_i` low, `byte_o` stays unchanged.
- R6: `byte_valid_o` is high exactly when the queue holds at least one byte.
- R7: The queue holds `DEPTH` (default 6) bytes. No request is raised while fewer than two slots are free, so a stalled consumer leaves the queue at 6 bytes from an even start or at 5 bytes from an odd start.
- R8: A redirect empties the queue in the cycle after `redirect_i` is high. No request is raised in the redirect cycle. The next request carries `redirect_addr_i`. A byte handshaken in the redirect cycle is not delivered.
- R9: A read that is in flight when a redirect occurs has its data discarded when it returns, even if it returns in the redirect cycle itself. No new request is raised until that data has returned.
- R10: A `mem_rvalid_i` pulse with no read in flight changes nothing: no byte is enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| redirect_i | input | 1 | Reload the fetch offset and flush the queue |
| redirect_addr_i | input | ADDR_W | New fetch offset for a redirect |
| mem_req_o | output | 1 | Word read request, taken in the same cycle |
| mem_addr_o | output | ADDR_W | Byte offset of the requested instruction byte |
| mem_rvalid_i | input | 1 | Read data returned this cycle |
| mem_rdata_i | input | 16 | Returned word, low byte at the even address |
| byte_o | output | 8 | Oldest queued instruction byte |
| byte_valid_o | output | 1 | Queue not empty |
| byte_ready_i | input | 1 | Consumer takes `byte_o` this cycle |

## Verification
The bench stalls the consumer after an even start and after an odd start and checks that fetching stops with six and with five bytes queued. A design that counted free slots wrongly would overrun the store or stall one word early. It redirects while a read is in flight with a long memory latency, and also in the exact cycle the data returns. A design that forgot the stale read would push bytes from the old stream into the new one, and the byte scoreboard would flag them. Odd targets check that only the upper byte is kept and that the offset steps by one; a design that kept both bytes would shift the whole stream by one. A stray return pulse with nothing in flight must add nothing, and any byte it added would show up as an extra byte in the stream.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;

    // Bytes produced by one returned word, in queue order
    typedef struct packed {
        logic  two;     // both bytes valid, else only first
        byte_t first;
        byte_t second;
    } fill_t;

    // Bookkeeping for the single in-flight word read
    typedef struct packed {
        logic busy;     // a read is in flight
        logic odd;      // it was issued at an odd offset
        logic stale;    // a redirect happened after it was issued
    } fetch_state_t;

    // Pick the stream bytes out of an aligned word
    function automatic fill_t split_word(input logic [WORD_W-1:0] w, input logic odd);
        fill_t f;
        if (odd) begin
            f.two    = 1'b0;
            f.first  = w[15:8];
            f.second = w[15:8];
        end else begin
            f.two    = 1'b1;
            f.first  = w[7:0];
            f.second = w[15:8];
        end
        return f;
    endfunction

endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              room2,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_valid,
    output fill_t             fill
);

    logic [ADDR_W-1:0] ptr_q;
    fetch_state_t      st_q;
    logic              issue;
    logic              resp;

    assign issue      = !rst && !redirect && !st_q.busy && room2;
    assign resp       = mem_rvalid && st_q.busy;
    assign fill_valid = resp && !st_q.stale && !redirect;
    assign fill       = split_word(mem_rdata, st_q.odd);
    assign mem_req    = issue;
    assign mem_addr   = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= RESET_ADDR;
            st_q  <= '0;
        end else begin
            if (redirect) begin
                ptr_q <= redirect_addr;
            end else if (issue) begin
                ptr_q <= ptr_q + (ptr_q[0] ? ADDR_W'(1) : ADDR_W'(2));
            end

            if (issue) begin
                st_q.busy  <= 1'b1;
                st_q.odd   <= ptr_q[0];
                st_q.stale <= 1'b0;
            end else if (resp) begin
                st_q <= '0;
            end else if (redirect && st_q.busy) begin
                st_q.stale <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push_valid,
    input  fill_t push_data,
    input  logic  pop,
    output byte_t head,
    output logic  head_valid,
    output logic  room2
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0]             rd_q, wr_q, wr_nx;
    logic [CNT_W-1:0]             cnt_q, push_n;
    logic                         take;
    logic [DEPTH-1:0][BYTE_W-1:0] slots;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    assign wr_nx      = bump(wr_q);
    assign head_valid = (cnt_q != '0);
    assign head       = slots[rd_q];
    assign room2      = (cnt_q <= CNT_W'(DEPTH - 2));
    assign take       = pop && head_valid;
    assign push_n     = !push_valid ? '0 : (push_data.two ? CNT_W'(2) : CNT_W'(1));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        byte_t slot_q;
        logic  we_first, we_second;
        assign we_first  = push_valid && (wr_q == IDX_W'(g));
        assign we_second = push_valid && push_data.two && (wr_nx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (we_first) begin
                slot_q <= push_data.first;
            end else if (we_second) begin
                slot_q <= push_data.second;
            end
        end
        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_valid) begin
                wr_q <= push_data.two ? bump(wr_nx) : wr_nx;
            end
            if (take) begin
                rd_q <= bump(rd_q);
            end
            cnt_q <= cnt_q + push_n - CNT_W'(take);
        end
    end

endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DEPTH      = 6,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_addr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [15:0]       mem_rdata_i,
    output logic [7:0]        byte_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i
);

    fill_t fill;
    logic  fill_valid;
    logic  room2;

    pfq_fetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .redirect      (redirect_i),
        .redirect_addr (redirect_addr_i),
        .room2         (room2),
        .mem_rvalid    (mem_rvalid_i),
        .mem_rdata     (mem_rdata_i),
        .mem_req       (mem_req_o),
        .mem_addr      (mem_addr_o),
        .fill_valid    (fill_valid),
        .fill          (fill)
    );

    pfq_byte_ring #(
        .DEPTH (DEPTH)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .flush      (redirect_i),
        .push_valid (fill_valid),
        .push_data  (fill),
        .pop        (byte_ready_i),
        .head       (byte_o),
        .head_valid (byte_valid_o),
        .room2      (room2)
    );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DEPTH  = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     redirect_i,
    input logic                     mem_req_o,
    input logic [ADDR_W-1:0]        mem_addr_o,
    input logic [7:0]               byte_o,
    input logic                     byte_valid_o,
    input logic                     byte_ready_i,
    input logic [$clog2(DEPTH+1)-1:0] occ
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] last_addr_q;
    logic              have_last_q;
    logic              redir_since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr_q   <= '0;
            have_last_q   <= 1'b0;
            redir_since_q <= 1'b0;
        end else if (mem_req_o) begin
            last_addr_q   <= mem_addr_o;
            have_last_q   <= 1'b1;
            redir_since_q <= 1'b0;
        end else if (redirect_i) begin
            redir_since_q <= 1'b1;
        end
    end

    // R2
    single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R7
    room_before_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (occ <= CNT_W'(DEPTH - 2)));

    // R8
    flush_on_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> !byte_valid_o);

    // R8
    no_fetch_on_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |-> !mem_req_o);

    // R3
    seq_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && have_last_q && !redir_since_q) |->
        (mem_addr_o == last_addr_q + (last_addr_q[0] ? ADDR_W'(1) : ADDR_W'(2))));

    // R5
    hold_head_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_o && !byte_ready_i && !redirect_i) |=> (byte_valid_o && $stable(byte_o)));

endmodule

bind insn_prefetch_queue pfq_checker #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .redirect_i   (redirect_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .occ          (u_ring.cnt_q)
);

// File: tb/test_insn_prefetch_queue.sv
module test_insn_prefetch_queue;

    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 6;
    localparam logic [15:0] BOOT       = 16'h0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redirect_i;
    logic [15:0] redirect_addr_i;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [15:0] mem_rdata_i  = '0;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic        byte_ready_i = 1'b0;

    logic        t_redir = 1'b0;
    logic [15:0] t_addr  = '0;
    logic        m_redir = 1'b0;
    logic [15:0] m_addr  = '0;

    assign redirect_i      = t_redir | m_redir;
    assign redirect_addr_i = m_redir ? m_addr : t_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_prefetch_queue i_insn_prefetch_queue (
        .clk             (clk),
        .rst             (rst),
        .redirect_i      (redirect_i),
        .redirect_addr_i (redirect_addr_i),
        .mem_req_o       (mem_req_o),
        .mem_addr_o      (mem_addr_o),
        .mem_rvalid_i    (mem_rvalid_i),
        .mem_rdata_i     (mem_rdata_i),
        .byte_o          (byte_o),
        .byte_valid_o    (byte_valid_o),
        .byte_ready_i    (byte_ready_i)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard of expected bytes
    logic [7:0] exp_q[$];

    task automatic sb_load(input logic [15:0] start);
        exp_q.delete();
        for (int i = 0; i < 512; i++) exp_q.push_back(pat(start + 16'(i)));
    endtask

    // bench model of the queue, built from the requirements
    bit          pending  = 1'b0;
    bit          pend_odd = 1'b0;
    bit          stale    = 1'b0;
    int          occ      = 0;
    logic [15:0] exp_ptr  = BOOT;
    string       addr_tag = "R1";

    // memory model
    bit          mem_busy = 1'b0;
    int          mem_cnt  = 0;
    logic [15:0] mem_base = '0;
    int          lat      = 1;
    bit          inject   = 1'b0;
    bit          redir_on_resp = 1'b0;

    always @(negedge clk) begin
        mem_rvalid_i = 1'b0;
        m_redir      = 1'b0;
        if (mem_busy) begin
            mem_cnt--;
            if (mem_cnt <= 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = {pat(mem_base + 16'd1), pat(mem_base)};
                mem_busy     = 1'b0;
                if (redir_on_resp) begin
                    m_redir       = 1'b1;
                    m_addr        = 16'h4001;
                    redir_on_resp = 1'b0;
                end
            end
        end else if (inject) begin
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = 16'hA5A5;
            inject       = 1'b0;
        end
    end

    // monitor: samples just before each rising edge
    initial begin
        sb_load(BOOT);
        forever begin
            bit popped;
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            if (rst) begin
                chk(!byte_valid_o, "R1", int'(byte_valid_o), 0);
                chk(!mem_req_o, "R1", int'(mem_req_o), 0);
                continue;
            end
            chk(byte_valid_o == (occ > 0), "R6", int'(byte_valid_o), int'(occ > 0));
            if (redirect_i) begin
                chk(!mem_req_o, "R8", int'(mem_req_o), 0);
            end else if (!pending && occ <= DEPTH - 2) begin
                chk(mem_req_o, "R2", int'(mem_req_o), 1);
            end
            if (mem_req_o) begin
                chk(!pending, stale ? "R9" : "R2", int'(pending), 0);
                chk(occ <= DEPTH - 2, "R7", occ, DEPTH - 2);
                chk(mem_addr_o == exp_ptr, addr_tag, int'(mem_addr_o), int'(exp_ptr));
            end
            popped = byte_valid_o && byte_ready_i && !redirect_i;
            if (popped) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", int'(byte_o), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_o == e, "R5", int'(byte_o), int'(e));
                end
                occ--;
            end
            if (mem_rvalid_i && pending) begin
                if (!stale && !redirect_i) occ += pend_odd ? 1 : 2;
                pending = 1'b0;
                stale   = 1'b0;
            end
            if (mem_req_o) begin
                pending  = 1'b1;
                pend_odd = mem_addr_o[0];
                stale    = 1'b0;
                exp_ptr  = mem_addr_o + (mem_addr_o[0] ? 16'd1 : 16'd2);
                addr_tag = mem_addr_o[0] ? "R4" : "R3";
                mem_busy = 1'b1;
                mem_cnt  = lat;
                mem_base = {mem_addr_o[15:1], 1'b0};
            end
            if (redirect_i) begin
                occ      = 0;
                exp_ptr  = redirect_addr_i;
                addr_tag = "R8";
                if (pending) stale = 1'b1;
                sb_load(redirect_addr_i);
            end
        end
    end

    task automatic do_redirect(input logic [15:0] a);
        t_addr  = a;
        t_redir = 1'b1;
        @(negedge clk);
        t_redir = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R7: stalled consumer, even start fills all six slots
        repeat (30) @(negedge clk);
        #1;
        chk(!mem_req_o, "R7", int'(mem_req_o), 0);
        chk(byte_valid_o, "R7", int'(byte_valid_o), 1);

        // R3, R5: streaming with a ready consumer
        byte_ready_i = 1'b1;
        repeat (60) @(negedge clk);

        // R5: intermittent consumer, slower memory
        lat = 3;
        for (int i = 0; i < 60; i++) begin
            byte_ready_i = (i % 3 != 0);
            @(negedge clk);
        end

        // R4, R7: odd target with stalled consumer stops at five bytes
        byte_ready_i = 1'b0;
        lat = 1;
        do_redirect(16'h1235);
        repeat (30) @(negedge clk);
        #1;
        chk(!mem_req_o, "R7", int'(mem_req_o), 0);
        chk(occ == 5, "R4", occ, 5);
        byte_ready_i = 1'b1;
        lat = 2;
        repeat (60) @(negedge clk);

        // R8, R9: redirects with reads in flight
        lat = 6;
        for (int i = 0; i < 8; i++) begin
            repeat (i + 2) @(negedge clk);
            do_redirect(16'h3000 + 16'(i * 7));
        end
        repeat (40) @(negedge clk);

        // R9: redirect in the very cycle the read returns
        lat = 3;
        redir_on_resp = 1'b1;
        wait (!redir_on_resp);
        repeat (40) @(negedge clk);

        // R10: stray return pulse with nothing in flight
        byte_ready_i = 1'b0;
        lat = 1;
        repeat (30) @(negedge clk);
        inject = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk(!mem_req_o, "R10", int'(mem_req_o), 0);
        chk(occ == DEPTH, "R10", occ, DEPTH);
        byte_ready_i = 1'b1;
        repeat (60) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule